// File: doc/BRIEF.md
# SPI-mode SD card block read responder

This block plays the card side of the SD card SPI-mode read path at byte granularity. It watches a mode-0 SPI slave interface, using a system clock to oversample it. For every byte the host clocks in, the block clocks one byte out. The host sends a six-byte command frame, which is one command byte, four argument bytes and one check byte. The block then replies with one filler byte and a one-byte R1 status.

For a read command, the block follows the status with one all-ones gap byte, a start token and a data block. It fetches the data byte by byte through a combinational read port, `rd_blk` and `rd_off` out and `rd_data` in, and ends the block with a 16-bit CRC. The gap between the status and the token always lasts exactly one byte time, which is eight SCLK cycles, for both single-block and multiple-block reads. In a multiple-block read, each following block is preceded by the same one-byte gap. Deasserting chip select at any time returns the block to waiting for a command.

Top module: `sdspi_read_resp`

## Requirements
- R1: While `spi_cs_n` is high, `spi_miso` is 1. Deasserting chip select at any point clears the bit and byte counters and returns the sequencer to command wait, so the next selected bytes read back 0xFF.
- R2: A received byte whose bits [7:6] are 2'b01 starts a command, and its bits [5:0] are the command index. In command wait, any other byte is ignored and 0xFF is returned.
- R3: The four bytes after the command byte form the argument, most significant byte first, and are used as the block number. The sixth byte is a check byte and is ignored. Every byte returned during the frame is 0xFF, and one more 0xFF byte follows before the status.
- R4: The status byte is 0x00 for index 17 (single-block read) and index 18 (multiple-block read). It is 0x04 for any other index. For the other indexes, the sequencer returns to command wait right after the status.
- R5: After a read status, exactly one 0xFF byte (eight SCLK cycles with MISO high) passes before the start token. The gap is never two bytes.
- R6: The start token 0xFE is followed by the block-length bytes (512 by default) taken from `rd_data`, with `rd_off` counting 0 upward and `rd_blk` holding the argument.
- R7: After each data block come two CRC bytes, high byte first. The CRC is CRC16 with polynomial 0x1021 and initial value 0x0000, computed over the data bytes only.
- R8: After the CRC of a single-block read, the block returns to command wait and sends 0xFF.
- R9: In a multiple-block read, each CRC is followed by one 0xFF gap byte and a new token, and then the data of the next block number (`rd_blk` plus 1). This repeats until chip select is deasserted.
- R10: SPI mode 0 is used: MOSI is captured on SCLK rising edges, MISO changes only after SCLK falling edges, and bytes go most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data to the host |
| rd_blk | output | 32 | Block number for the read port |
| rd_off | output | $clog2(BLK_LEN) | Byte offset within the block for the read port |
| rd_data | input | 8 | Data byte at `rd_blk`/`rd_off`, combinational |

## Verification
A wrong sequencer state shows up on MISO within one byte time. A slip in state order either moves the status, gap or token byte by a whole byte position, or turns an expected 0xFF into something else. For this reason, the bench compares every returned byte against its position in the expected stream. A wrong offset counter or CRC register stays hidden until the data is compared or the CRC bytes arrive. The bench models the memory as a function of block and offset, so one misplaced byte changes both the data comparison and the CRC.

// File: rtl/sdspi_pkg.sv
// Shared types and constants for the SPI-mode SD read responder.
// Assumes byte-granular sequencing; the CRC helper folds one byte MSB first.
package sdspi_pkg;

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a command byte, sending 0xFF
        S_ARG,    // receiving argument and check bytes
        S_NCR,    // one filler byte before the status
        S_RESP,   // status byte on the wire
        S_NAC,    // one-byte gap before the token
        S_TOKEN,  // start token on the wire
        S_DATA,   // data bytes on the wire
        S_CRC     // two CRC bytes on the wire
    } seq_st_t;

    localparam logic [7:0] BYTE_IDLE  = 8'hFF;
    localparam logic [7:0] BYTE_TOKEN = 8'hFE;
    localparam logic [7:0] STAT_OK    = 8'h00;
    localparam logic [7:0] STAT_ILL   = 8'h04;
    localparam logic [5:0] IDX_RD_ONE = 6'd17;
    localparam logic [5:0] IDX_RD_MANY = 6'd18;
    localparam logic [15:0] CRC_POLY  = 16'h1021;

    // Fold one byte into a CRC16 value, most significant bit first.
    function automatic logic [15:0] crc16_fold(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/sdspi_byte_port.sv
// Mode-0 SPI slave byte port. It oversamples SCLK, MOSI and CS with the
// system clock, assembles received bytes on SCLK rises, and shifts MISO on
// SCLK falls. Assumes SCLK half period of at least four system clocks.
module sdspi_byte_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       cs_n,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       cs_idle,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       tx_load
);
    logic [1:0] sclk_sy, mosi_sy, cs_sy;
    logic       sclk_d;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       pend;
    logic       rise, fall;

    assign cs_idle = cs_sy[1];
    assign rise    = sclk_sy[1] & ~sclk_d & ~cs_idle;
    assign fall    = ~sclk_sy[1] & sclk_d & ~cs_idle;
    assign tx_load = fall & pend;
    assign miso    = tx_sh[7];

    // Two-stage synchronisers and edge history for the SPI pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sy <= '0;
            mosi_sy <= '0;
            cs_sy   <= '1;
            sclk_d  <= 1'b0;
        end else begin
            sclk_sy <= {sclk_sy[0], sclk};
            mosi_sy <= {mosi_sy[0], mosi};
            cs_sy   <= {cs_sy[0], cs_n};
            sclk_d  <= sclk_sy[1];
        end
    end

    // Receive and transmit shifting with a byte-complete handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= BYTE_ALL1;
            pend     <= 1'b0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                rx_sh <= {rx_sh[5:0], mosi_sy[1]};
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh, mosi_sy[1]};
                    pend     <= 1'b1;
                end
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (fall) begin
                if (pend) begin
                    tx_sh <= tx_byte;
                    pend  <= 1'b0;
                end else begin
                    tx_sh <= {tx_sh[6:0], 1'b1};
                end
            end
        end
    end

    localparam logic [7:0] BYTE_ALL1 = 8'hFF;
endmodule

// File: rtl/sdspi_crc16.sv
// CRC16 accumulator over the outgoing data bytes. Cleared when the start
// token is loaded; folds each data byte as it is loaded for transmission.
module sdspi_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import sdspi_pkg::*;

    // Accumulate or clear the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= '0;
        else if (en)       crc <= crc16_fold(crc, din);
    end
endmodule

// File: rtl/sdspi_seq.sv
// Byte sequencer for the read path. It advances once per received byte and
// names the byte currently on MISO; the next outgoing byte is derived
// combinationally from the state. Assumes a combinational read port.
module sdspi_seq #(
    parameter int BLK_LEN = 512,
    localparam int CNT_W  = $clog2(BLK_LEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_idle,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    input  logic [15:0]           crc,
    input  logic [7:0]            rd_data,
    output logic [7:0]            tx_byte,
    output logic [31:0]           rd_blk,
    output logic [CNT_W-1:0]      rd_off,
    output sdspi_pkg::seq_st_t    st,
    output logic [CNT_W-1:0]      cnt,
    output logic                  is_read
);
    import sdspi_pkg::*;

    localparam logic [CNT_W-1:0] LAST_OFF = CNT_W'(BLK_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_ARG = CNT_W'(4);

    logic [5:0]  cmd_idx;
    logic [31:0] arg;
    logic        multi;

    assign is_read = (cmd_idx == IDX_RD_ONE) || (cmd_idx == IDX_RD_MANY);
    assign multi   = (cmd_idx == IDX_RD_MANY);
    assign rd_off  = (st == S_DATA) ? cnt : '0;

    // Outgoing byte chosen by the state in force at the next load.
    always_comb begin
        unique case (st)
            S_RESP:  tx_byte = is_read ? STAT_OK : STAT_ILL;
            S_TOKEN: tx_byte = BYTE_TOKEN;
            S_DATA:  tx_byte = rd_data;
            S_CRC:   tx_byte = (cnt == '0) ? crc[15:8] : crc[7:0];
            default: tx_byte = BYTE_IDLE;
        endcase
    end

    // State, counter and argument update on each received byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            st  <= S_IDLE;
            cnt <= '0;
            if (!rst_n) begin
                cmd_idx <= '0;
                arg     <= '0;
                rd_blk  <= '0;
            end
        end else if (rx_valid) begin
            unique case (st)
                S_IDLE: if (rx_byte[7:6] == 2'b01) begin
                    cmd_idx <= rx_byte[5:0];
                    st      <= S_ARG;
                    cnt     <= '0;
                end
                S_ARG: begin
                    if (cnt != LAST_ARG) arg <= {arg[23:0], rx_byte};
                    if (cnt == LAST_ARG) begin
                        st  <= S_NCR;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_NCR:   st <= S_RESP;
                S_RESP: begin
                    st     <= is_read ? S_NAC : S_IDLE;
                    rd_blk <= arg;
                end
                S_NAC:   st <= S_TOKEN;
                S_TOKEN: begin
                    st  <= S_DATA;
                    cnt <= '0;
                end
                S_DATA: begin
                    if (cnt == LAST_OFF) begin
                        st  <= S_CRC;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_CRC: begin
                    if (cnt != '0) begin
                        cnt <= '0;
                        if (multi) begin
                            st     <= S_NAC;
                            rd_blk <= rd_blk + 32'd1;
                        end else begin
                            st <= S_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdspi_read_resp.sv
// Top of the SPI-mode SD read responder: byte port, sequencer and CRC16
// accumulator. Assumes the read port returns rd_data in the same cycle.
module sdspi_read_resp #(
    parameter int BLK_LEN = 512,
    localparam int CNT_W  = $clog2(BLK_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    input  logic             spi_cs_n,
    output logic             spi_miso,
    output logic [31:0]      rd_blk,
    output logic [CNT_W-1:0] rd_off,
    input  logic [7:0]       rd_data
);
    import sdspi_pkg::*;

    logic             cs_idle, rx_valid, tx_load, seq_is_read;
    logic [7:0]       rx_byte, tx_byte;
    logic [15:0]      crc;
    logic [CNT_W-1:0] seq_cnt;
    seq_st_t          seq_state;

    sdspi_byte_port u_port (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi),
        .cs_n(spi_cs_n), .tx_byte(tx_byte), .miso(spi_miso),
        .cs_idle(cs_idle), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_load(tx_load)
    );

    sdspi_seq #(.BLK_LEN(BLK_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .crc(crc), .rd_data(rd_data), .tx_byte(tx_byte),
        .rd_blk(rd_blk), .rd_off(rd_off), .st(seq_state), .cnt(seq_cnt),
        .is_read(seq_is_read)
    );

    sdspi_crc16 u_crc (
        .clk(clk), .rst_n(rst_n),
        .clr(tx_load && seq_state == S_TOKEN),
        .en(tx_load && seq_state == S_DATA),
        .din(rd_data), .crc(crc)
    );
endmodule

// File: rtl/sdspi_read_resp_chk.sv
// Property checker for the read responder, bound into the top module.
module sdspi_read_resp_chk #(
    parameter int CNT_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_idle,
    input logic               rx_valid,
    input logic               tx_load,
    input logic               miso,
    input logic               is_read,
    input sdspi_pkg::seq_st_t st,
    input logic [CNT_W-1:0]   cnt
);
    import sdspi_pkg::*;

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (st == S_IDLE && miso)); // R1

    AST_ARG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ARG) |-> (cnt <= CNT_W'(4))); // R3

    AST_READ_TO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st == S_RESP && is_read && !cs_idle) |=> (st == S_NAC)); // R4

    AST_GAP_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st == S_NAC && !cs_idle) |=> (st == S_TOKEN)); // R5

    AST_GAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && st == S_NAC && !cs_idle) |=> miso); // R5
endmodule

bind sdspi_read_resp sdspi_read_resp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .rx_valid(rx_valid),
    .tx_load(tx_load), .miso(spi_miso), .is_read(seq_is_read),
    .st(seq_state), .cnt(seq_cnt)
);

// File: tb/sdspi_read_resp_bench.sv
// Directed bench for the SPI-mode SD read responder.
module sdspi_read_resp_bench;
    localparam int HALF = 5;
    localparam int BLK  = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_mosi = 1'b1, spi_cs_n = 1'b1;
    logic       spi_miso;
    logic [31:0] rd_blk;
    logic [8:0]  rd_off;
    logic [7:0]  rd_data;
    int n_cmp = 0, n_bad = 0, edge_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [31:0] b, input logic [8:0] o);
        logic [31:0] v;
        v = b * 32'd29 + {23'd0, o} * 32'd7 + {27'd0, o[8:4]};
        return v[7:0];
    endfunction

    assign rd_data = mem_byte(rd_blk, rd_off);

    sdspi_read_resp u_sdspi_read_resp (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .rd_blk(rd_blk),
        .rd_off(rd_off), .rd_data(rd_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ d[i];
            r = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (spi_miso !== rx[i]) edge_err++;
            spi_sclk = 1'b0;
        end
    endtask

    task automatic select(input logic on);
        spi_cs_n = ~on;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg);
        logic [7:0] r;
        xfer({2'b01, idx}, r);  chk(r, 8'hFF, "R2 command byte echo");
        for (int k = 3; k >= 0; k--) begin
            xfer(arg[8*k +: 8], r); chk(r, 8'hFF, "R3 argument echo");
        end
        xfer(8'h5A, r); chk(r, 8'hFF, "R3 check byte echo");
        xfer(8'hFF, r); chk(r, 8'hFF, "R3 filler before status");
    endtask

    task automatic read_block(input logic [31:0] b, input string tag);
        logic [7:0] r;
        logic [15:0] c;
        c = 16'h0000;
        xfer(8'hFF, r); chk(r, 8'hFE, "R6 start token");
        chk(rd_blk, b, "R6 block number");
        for (int k = 0; k < BLK; k++) begin
            xfer(8'hFF, r);
            chk(r, mem_byte(b, 9'(k)), {tag, " data byte"});
            c = ref_crc(c, mem_byte(b, 9'(k)));
        end
        xfer(8'hFF, r); chk(r, c[15:8], "R7 crc high");
        xfer(8'hFF, r); chk(r, c[7:0], "R7 crc low");
    endtask

    task automatic t_reset();
        chk(spi_miso, 1'b1, "R1 miso high at reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(spi_miso, 1'b1, "R1 miso high deselected");
    endtask

    task automatic t_illegal();
        logic [7:0] r;
        select(1);
        xfer(8'hFF, r); chk(r, 8'hFF, "R2 idle byte ignored");
        xfer(8'h11, r); chk(r, 8'hFF, "R2 non-command byte ignored");
        xfer(8'hFF, r); chk(r, 8'hFF, "R2 still waiting");
        send_cmd(6'd9, 32'h0000_0001);
        xfer(8'hFF, r); chk(r, 8'h04, "R4 illegal status");
        xfer(8'hFF, r); chk(r, 8'hFF, "R4 back to wait");
        send_cmd(6'd13, 32'h0);
        xfer(8'hFF, r); chk(r, 8'h04, "R4 second illegal status");
        xfer(8'hFF, r); chk(r, 8'hFF, "R4 no gap token after illegal");
        select(0);
    endtask

    task automatic t_single();
        logic [7:0] r;
        select(1);
        send_cmd(6'd17, 32'h0000_0003);
        xfer(8'hFF, r); chk(r, 8'h00, "R4 read status");
        xfer(8'hFF, r); chk(r, 8'hFF, "R5 single gap byte");
        read_block(32'd3, "R6 single");
        xfer(8'hFF, r); chk(r, 8'hFF, "R8 idle after crc");
        xfer(8'hFF, r); chk(r, 8'hFF, "R8 still idle");
        select(0);
    endtask

    task automatic t_multi();
        logic [7:0] r;
        select(1);
        send_cmd(6'd18, 32'h0000_0005);
        xfer(8'hFF, r); chk(r, 8'h00, "R4 multi read status");
        xfer(8'hFF, r); chk(r, 8'hFF, "R5 first gap byte");
        read_block(32'd5, "R9 block 0");
        xfer(8'hFF, r); chk(r, 8'hFF, "R9 gap between blocks");
        read_block(32'd6, "R9 block 1");
        xfer(8'hFF, r); chk(r, 8'hFF, "R9 third gap");
        select(0);
        chk(spi_miso, 1'b1, "R1 miso high after stop");
    endtask

    task automatic t_abort();
        logic [7:0] r;
        select(1);
        send_cmd(6'd17, 32'h0000_0002);
        xfer(8'hFF, r); chk(r, 8'h00, "R4 status before abort");
        xfer(8'hFF, r); chk(r, 8'hFF, "R5 gap before abort");
        xfer(8'hFF, r); chk(r, 8'hFE, "R6 token before abort");
        xfer(8'hFF, r); chk(r, mem_byte(32'd2, 9'd0), "R6 first byte before abort");
        spi_mosi = 1'b0;
        spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 1'b0;
        select(0);
        chk(spi_miso, 1'b1, "R1 miso high on abort");
        select(1);
        xfer(8'hFF, r); chk(r, 8'hFF, "R1 idle after reselect");
        xfer(8'hFF, r); chk(r, 8'hFF, "R1 no data after reselect");
        send_cmd(6'd20, 32'h0);
        xfer(8'hFF, r); chk(r, 8'h04, "R1 command wait after abort");
        select(0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_illegal();
        t_single();
        t_multi();
        t_abort();
        chk(edge_err, 0, "R10 miso stable across rising edges");
        done = 1;
        finish_run();
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule